// File: doc/BRIEF.md
# Atomic compare-and-swap memory unit

This block is a small word-addressed storage array shared by several requesters. Each requester presents a load, a store or a compare-and-swap (CAS) on its own valid/ready request port. A fixed-priority arbiter picks one requester per cycle, and the lowest index wins. Every accepted request produces a one-cycle response pulse to its owner. The pulse carries the word that was held at the address before the operation and a success flag.

A CAS supplies an address, an expected word and a new word. The block reads the word in the accept cycle. In the next cycle it compares the word and writes the new word only on a match. During that second cycle the grant stays locked and no other request is accepted, so the read-compare-write cannot be split by another access. A requester that sees a failure can retry with the returned word as its next expected value.

When the tagged mode is enabled, each 64-bit word is split in two. Bits 31:0 hold a payload and bits 63:32 hold a version counter. The counter is advanced on every store and on every successful CAS, and it wraps modulo 2^32. A payload that changes and later returns to an earlier value still fails a stale CAS.

Top module: `cas_mem`

## Requirements
- R1: A load (op 2'b00) to address A raises resp_valid for its requester one cycle after the handshake. resp_rdata is the word at A and resp_success is 1. The word is unchanged.
- R2: A store (op 2'b01) writes its data to address A. The response, one cycle after the handshake, returns the prior word of A with resp_success 1.
- R3: A CAS (op 2'b10) whose expected word equals the word at A writes the new word to A. The response returns the prior word with resp_success 1.
- R4: A CAS whose expected word differs from the word at A leaves A unchanged. The response returns the word at A with resp_success 0.
- R5: A CAS responds two cycles after its handshake. In the cycle after the handshake every req_ready is 0. A request waiting in that cycle is served only after the CAS has written.
- R6: At most one req_ready is high at a time. It belongs to the lowest-indexed requester with req_valid high.
- R7: In tagged mode (TAGGED=1) the comparison covers all 64 bits. A store writes wdata[31:0] as the payload and sets bits 63:32 to the prior version plus 1, ignoring wdata[63:32]. A successful CAS writes the new word's bits 31:0 with the prior version plus 1. A stale version with a matching payload fails.
- R8: After reset every word reads as zero, including its version field, and no resp_valid is high.
- R9: The op code 2'b11 behaves as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle, one bit per requester |
| req_op | input | 2*NREQ | Per-requester operation: 00 load, 01 store, 10 CAS, 11 load |
| req_addr | input | AW*NREQ | Per-requester word address |
| req_wdata | input | DW*NREQ | Per-requester store data or CAS new word |
| req_cmp | input | DW*NREQ | Per-requester CAS expected word |
| resp_valid | output | NREQ | One-cycle response pulse to the owner of the finished request |
| resp_rdata | output | DW | Word held at the address before the operation |
| resp_success | output | 1 | 1 for load, store and matching CAS; 0 for a failed CAS |

## Verification
The assertions assume that a requester holds its op, address and data stable while its valid is high and unaccepted. They also assume that inputs change only away from the rising edge, and that each requester keeps at most one request in flight. The bench drives all requests at the falling edge and drops valid right after the accepting edge. The arbitration and locking cases are the only ones where it raises two valids at once, and there it leaves the losing request pending unchanged until that request is accepted.

// File: rtl/cas_mem.sv
module cas_mem #(
  parameter int NREQ   = 3,
  parameter int AW     = 4,
  parameter int DW     = 64,
  parameter bit TAGGED = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_valid,
  output logic [NREQ-1:0]     req_ready,
  input  logic [2*NREQ-1:0]   req_op,
  input  logic [AW*NREQ-1:0]  req_addr,
  input  logic [DW*NREQ-1:0]  req_wdata,
  input  logic [DW*NREQ-1:0]  req_cmp,
  output logic [NREQ-1:0]     resp_valid,
  output logic [DW-1:0]       resp_rdata,
  output logic                resp_success
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = DW / 2;
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [1:0] OP_ST  = 2'b01;
  localparam logic [1:0] OP_CAS = 2'b10;

  logic [DW-1:0] mem [DEPTH];
  logic          busy;
  logic [IW-1:0] c_idx;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_cmp, c_wval, rd_q;

  logic [NREQ-1:0] gnt;
  logic [IW-1:0]   gidx;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gidx    = IW'(i);
      end
    end
  end

  assign req_ready = busy ? '0 : gnt;

  wire          hs    = |req_ready;
  wire [1:0]    s_op  = req_op[gidx*2 +: 2];
  wire [AW-1:0] s_addr = req_addr[gidx*AW +: AW];
  wire [DW-1:0] s_cmp = req_cmp[gidx*DW +: DW];
  wire [DW-1:0] cur   = mem[s_addr];
  wire          match = (rd_q == c_cmp);
  logic [DW-1:0] st_val, new_val;

  generate
    if (TAGGED) begin : g_tag
      assign st_val  = {cur[DW-1:PW] + PW'(1), req_wdata[gidx*DW +: PW]};
      assign new_val = st_val;
    end else begin : g_plain
      assign st_val  = req_wdata[gidx*DW +: DW];
      assign new_val = st_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      busy         <= 1'b0;
      c_idx        <= '0;
      c_addr       <= '0;
      c_cmp        <= '0;
      c_wval       <= '0;
      rd_q         <= '0;
      resp_valid   <= '0;
      resp_rdata   <= '0;
      resp_success <= 1'b0;
    end else begin
      resp_valid <= '0;
      if (busy) begin
        busy              <= 1'b0;
        resp_valid[c_idx] <= 1'b1;
        resp_rdata        <= rd_q;
        resp_success      <= match;
        if (match) mem[c_addr] <= c_wval;
      end else if (hs) begin
        if (s_op == OP_CAS) begin
          busy   <= 1'b1;
          c_idx  <= gidx;
          c_addr <= s_addr;
          c_cmp  <= s_cmp;
          c_wval <= new_val;
          rd_q   <= cur;
        end else begin
          resp_valid[gidx] <= 1'b1;
          resp_rdata       <= cur;
          resp_success     <= 1'b1;
          if (s_op == OP_ST) mem[s_addr] <= st_val;
        end
      end
    end
  end

  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_ready - 1'b1) & req_valid & {NREQ{|req_ready}}) == '0);

  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && s_op == OP_CAS) |=> (req_ready == '0));

  a_r1_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_valid));

  a_r4_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !match) |=> (mem[$past(c_addr)] == $past(rd_q)));

  a_r3_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && match) |=> (resp_success && resp_rdata == $past(rd_q)));

  generate
    if (TAGGED) begin : g_tag_chk
      a_r7_version_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && match) |=> (mem[$past(c_addr)][DW-1:PW] == $past(rd_q[DW-1:PW]) + PW'(1)));
    end
  endgenerate
endmodule

// File: tb/cas_mem_test.sv
`timescale 1ns/1ps
module cas_mem_test;
  localparam int NREQ = 3;
  localparam int AW   = 4;
  localparam int DW   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [NREQ-1:0]    req_ready;
  logic [2*NREQ-1:0]  req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [DW*NREQ-1:0] req_cmp = '0;
  logic [NREQ-1:0]    resp_valid;
  logic [DW-1:0]      resp_rdata;
  logic               resp_success;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cas_mem #(.NREQ(NREQ), .AW(AW), .DW(DW), .TAGGED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_success(resp_success));

  typedef struct packed {
    logic [1:0]  who;
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [63:0] wdata;
    logic [63:0] cmp;
    logic [63:0] exp_rd;
    logic        exp_ok;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'b00, 4'd3, 64'h0, 64'h0, 64'h0, 1'b1},
    '{2'd1, 2'b01, 4'd3, 64'h0000_0000_0000_00AA, 64'h0, 64'h0, 1'b1},
    '{2'd2, 2'b00, 4'd3, 64'h0, 64'h0, 64'h0000_0001_0000_00AA, 1'b1},
    '{2'd0, 2'b10, 4'd3, 64'h0000_0000_0000_00CC, 64'h0000_0000_0000_00AA, 64'h0000_0001_0000_00AA, 1'b0},
    '{2'd1, 2'b10, 4'd3, 64'h0000_0000_0000_00BB, 64'h0000_0001_0000_00AA, 64'h0000_0001_0000_00AA, 1'b1},
    '{2'd0, 2'b10, 4'd3, 64'h0000_0000_0000_00AA, 64'h0000_0002_0000_00BB, 64'h0000_0002_0000_00BB, 1'b1},
    '{2'd2, 2'b10, 4'd3, 64'h0000_0000_0000_00DD, 64'h0000_0001_0000_00AA, 64'h0000_0003_0000_00AA, 1'b0},
    '{2'd0, 2'b00, 4'd3, 64'h0, 64'h0, 64'h0000_0003_0000_00AA, 1'b1},
    '{2'd1, 2'b11, 4'd3, 64'h0, 64'h0, 64'h0000_0003_0000_00AA, 1'b1},
    '{2'd0, 2'b00, 4'd15, 64'h0, 64'h0, 64'h0, 1'b1},
    '{2'd2, 2'b01, 4'd15, 64'hFFFF_FFFF_1234_5678, 64'h0, 64'h0, 1'b1},
    '{2'd0, 2'b00, 4'd15, 64'h0, 64'h0, 64'h0000_0001_1234_5678, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int k, input logic [1:0] op, input logic [3:0] a,
                       input logic [63:0] wd, input logic [63:0] cp);
    req_op[k*2 +: 2]      = op;
    req_addr[k*AW +: AW]  = a;
    req_wdata[k*DW +: DW] = wd;
    req_cmp[k*DW +: DW]   = cp;
    req_valid[k]          = 1'b1;
  endtask

  task automatic run(input int k, input logic [1:0] op, input logic [3:0] a,
                     input logic [63:0] wd, input logic [63:0] cp,
                     input logic [63:0] erd, input logic eok, input string tag);
    logic [NREQ-1:0] one;
    one = '0;
    one[k] = 1'b1;
    drive(k, op, a, wd, cp);
    #1;
    chk({tag, " R6 ready"}, 64'(req_ready), 64'(one));
    @(posedge clk);
    @(negedge clk);
    req_valid[k] = 1'b0;
    if (op == 2'b10) begin
      chk({tag, " R5 no resp yet"}, 64'(resp_valid), 64'h0);
      @(negedge clk);
    end
    chk({tag, " resp_valid"}, 64'(resp_valid), 64'(one));
    chk({tag, " rdata"}, resp_rdata, erd);
    chk({tag, " success"}, 64'(resp_success), 64'(eok));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 resp_valid in reset", 64'(resp_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 resp_valid after reset", 64'(resp_valid), 64'h0);
    chk("R6 no ready without valid", 64'(req_ready), 64'h0);

    // R1 R2 R3 R4 R7 R8 R9: vector walk on addresses 3 and 15
    for (int v = 0; v < NV; v++) begin
      run(int'(VEC[v].who), VEC[v].op, VEC[v].addr, VEC[v].wdata, VEC[v].cmp,
          VEC[v].exp_rd, VEC[v].exp_ok, $sformatf("vec%0d R1-set", v));
    end

    // R6: requesters 1 and 2 both load; 1 goes first
    drive(1, 2'b00, 4'd3, 64'h0, 64'h0);
    drive(2, 2'b00, 4'd15, 64'h0, 64'h0);
    #1;
    chk("R6 lowest first", 64'(req_ready), 64'h2);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk("R6 resp to r1", 64'(resp_valid), 64'h2);
    chk("R6 r1 rdata", resp_rdata, 64'h0000_0003_0000_00AA);
    #1;
    chk("R6 r2 next", 64'(req_ready), 64'h4);
    @(posedge clk);
    @(negedge clk);
    req_valid[2] = 1'b0;
    chk("R6 r2 rdata", resp_rdata, 64'h0000_0001_1234_5678);

    // R5: r1 CAS on address 5, then r0 store waits through the compare cycle
    drive(1, 2'b10, 4'd5, 64'h0000_0000_0000_0077, 64'h0);
    #1;
    chk("R5 cas ready", 64'(req_ready), 64'h2);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    drive(0, 2'b01, 4'd5, 64'h0000_0000_0000_0099, 64'h0);
    #1;
    chk("R5 locked ready", 64'(req_ready), 64'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 cas resp", 64'(resp_valid), 64'h2);
    chk("R3 cas rdata", resp_rdata, 64'h0);
    chk("R3 cas ok", 64'(resp_success), 64'h1);
    #1;
    chk("R5 store now ready", 64'(req_ready), 64'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid[0] = 1'b0;
    chk("R5 store saw cas word", resp_rdata, 64'h0000_0001_0000_0077);
    run(2, 2'b00, 4'd5, 64'h0, 64'h0, 64'h0000_0002_0000_0099, 1'b1, "R2 R7 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule